// File: doc/BRIEF.md
# Transmit/Receive Queue Interrupt Condition Controller

This block tracks one interrupt condition per queue for a peripheral that moves data through sixteen receive and sixteen transmit descriptor queues. Receive conditions are raised by a one-cycle completion pulse per queue. Software clears them by writing ones to a write-only clear word.

Transmit conditions use a completion-pointer handshake. When a transmit queue finishes a descriptor, the port writes that descriptor's pointer into the queue's pointer register, and this raises the queue's condition. Software reclaims buffers and then writes back the pointer of the last descriptor it reclaimed. The condition drops only if that value equals the pointer the port stored. A single interrupt line, registered once, reports whether any condition in either direction is pending.

Everything is reached through a simple word-addressed register bus. Reads are combinational in the same cycle, and writes take effect on the next rising edge.

Top module: `qcp_intc`

## Requirements
- R1: After synchronous reset, both status words read zero, every transmit pointer reads zero, and `irq` is 0.
- R2: A 1 on `rx_done[n]` sets receive status bit n, which is visible at offset 0x240 in the following cycle. Bits 31:16 of any status read are zero.
- R3: Writing the receive clear word (offset 0x248) clears each receive status bit whose write-data bit is 1 and leaves bits written 0 unchanged. A read of either clear word (0x248, 0x258) returns zero.
- R4: A port write (`tx_port_we` with queue `tx_port_q` and value `tx_port_ptr`) sets transmit status bit q, read at offset 0x250. It also stores the value, which is read back at offset 0x280 + 4·q.
- R5: A bus write to transmit pointer word q clears transmit status bit q when the written value equals the stored port pointer. If the values differ, the bit stays set.
- R6: A 1 written to bit q of the transmit clear word (0x258) clears transmit status bit q only when the last value software wrote to pointer word q equals the stored port pointer. Otherwise the write has no effect.
- R7: When a hardware set and a clear for the same status bit happen in the same cycle, the bit ends up set.
- R8: A port write that follows a matching software acknowledge sets the transmit condition again.
- R9: `irq` equals the OR of all receive and transmit status bits as they stood one cycle earlier.
- R10: Reads of unmapped or non-word-aligned offsets return zero, and writes to them change no state.
- R11: Reads of a transmit pointer word return the port-written value, whatever software last wrote there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when no read |
| rx_done | input | 16 | Per-queue receive completion pulses |
| tx_port_we | input | 1 | Port stores a completed-descriptor pointer |
| tx_port_q | input | 4 | Transmit queue index for the port write |
| tx_port_ptr | input | 32 | Pointer value written by the port |
| irq | output | 1 | Registered OR of all pending conditions |

## Verification
The assertions check on every cycle that `irq` follows the combined status with one cycle of delay, that completion pulses and port writes always leave their bits set, and that a transmit bit never falls unless a bus write happened in the cycle before. They also check that status reads keep their upper half zero, that unaligned reads return zero, and that reset clears everything. Only the bench scenarios can show the handshake itself: a mismatched pointer leaves the condition pending, the gated clear word depends on the last acknowledge, a fresh port write re-arms a queue, and set wins over clear in the same cycle.

// File: rtl/qcp_pkg.sv
package qcp_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;

    localparam int OFF_RX_STAT = 'h240;
    localparam int OFF_RX_CLR  = 'h248;
    localparam int OFF_TX_STAT = 'h250;
    localparam int OFF_TX_CLR  = 'h258;
    localparam int OFF_PTR0    = 'h280;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_RX,
        RSEL_TX,
        RSEL_PTR
    } qcp_rsel_e;

    typedef struct packed {
        logic      rx_clr_we;
        logic      tx_clr_we;
        logic      ptr_we;
        qcp_rsel_e rsel;
        logic [7:0] q;
    } qcp_dec_t;

    function automatic qcp_dec_t qcp_decode(
        input logic              en,
        input logic              wr,
        input logic [ADDR_W-1:0] addr,
        input int                num_q
    );
        qcp_dec_t d;
        int       a;
        logic     ptr_hit;
        d       = '0;
        d.rsel  = RSEL_NONE;
        a       = int'(addr);
        ptr_hit = (a >= OFF_PTR0) && (a < OFF_PTR0 + 4 * num_q) && (addr[1:0] == 2'b00);
        if (ptr_hit) begin
            d.q = 8'((a - OFF_PTR0) >> 2);
        end
        if (en && wr) begin
            d.rx_clr_we = (a == OFF_RX_CLR);
            d.tx_clr_we = (a == OFF_TX_CLR);
            d.ptr_we    = ptr_hit;
        end else if (en) begin
            if (a == OFF_RX_STAT)      d.rsel = RSEL_RX;
            else if (a == OFF_TX_STAT) d.rsel = RSEL_TX;
            else if (ptr_hit)          d.rsel = RSEL_PTR;
        end
        return d;
    endfunction

endpackage

// File: rtl/qcp_cond_bits.sv
module qcp_cond_bits #(
    parameter int NUM_Q = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_Q-1:0] set_i,
    input  logic [NUM_Q-1:0] clr_i,
    output logic [NUM_Q-1:0] stat_o
);
    // a set in the same cycle as a clear keeps the bit
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_o <= '0;
        end else begin
            stat_o <= (stat_o & ~clr_i) | set_i;
        end
    end
endmodule

// File: rtl/qcp_tx_queue.sv
module qcp_tx_queue #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_we,
    input  logic [PTR_W-1:0] port_ptr,
    input  logic             ack_we,
    input  logic [PTR_W-1:0] ack_ptr,
    input  logic             clr_req,
    output logic             stat_o,
    output logic [PTR_W-1:0] port_ptr_o
);
    logic [PTR_W-1:0] sw_ptr_q;
    logic             ack_match;
    logic             clr_ok;

    assign ack_match = ack_we && (ack_ptr == port_ptr_o);
    assign clr_ok    = clr_req && (sw_ptr_q == port_ptr_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_ptr_o <= '0;
            sw_ptr_q   <= '0;
            stat_o     <= 1'b0;
        end else begin
            if (port_we) port_ptr_o <= port_ptr;
            if (ack_we)  sw_ptr_q   <= ack_ptr;
            if (port_we)                   stat_o <= 1'b1;
            else if (ack_match || clr_ok)  stat_o <= 1'b0;
        end
    end
endmodule

// File: rtl/qcp_irq.sv
module qcp_irq #(
    parameter int NUM_Q = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_Q-1:0] rx_stat,
    input  logic [NUM_Q-1:0] tx_stat,
    output logic             irq_o
);
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= (|rx_stat) | (|tx_stat);
    end
endmodule

// File: rtl/qcp_intc.sv
module qcp_intc
    import qcp_pkg::*;
#(
    parameter int NUM_Q = 16,
    localparam int QW   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_Q-1:0]  rx_done,
    input  logic              tx_port_we,
    input  logic [QW-1:0]     tx_port_q,
    input  logic [DATA_W-1:0] tx_port_ptr,
    output logic              irq
);
    qcp_dec_t                dec;
    logic [NUM_Q-1:0]        rx_stat;
    logic [NUM_Q-1:0]        tx_stat;
    logic [NUM_Q-1:0]        rx_clr;
    logic [DATA_W-1:0]       port_ptr [NUM_Q];

    assign dec    = qcp_decode(bus_en, bus_wr, bus_addr, NUM_Q);
    assign rx_clr = dec.rx_clr_we ? bus_wdata[NUM_Q-1:0] : '0;

    qcp_cond_bits #(.NUM_Q(NUM_Q)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .set_i  (rx_done),
        .clr_i  (rx_clr),
        .stat_o (rx_stat)
    );

    for (genvar i = 0; i < NUM_Q; i++) begin : g_txq
        qcp_tx_queue #(.PTR_W(DATA_W)) u_q (
            .clk        (clk),
            .rst        (rst),
            .port_we    (tx_port_we && (tx_port_q == QW'(i))),
            .port_ptr   (tx_port_ptr),
            .ack_we     (dec.ptr_we && (dec.q == 8'(i))),
            .ack_ptr    (bus_wdata),
            .clr_req    (dec.tx_clr_we && bus_wdata[i]),
            .stat_o     (tx_stat[i]),
            .port_ptr_o (port_ptr[i])
        );
    end

    qcp_irq #(.NUM_Q(NUM_Q)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .rx_stat (rx_stat),
        .tx_stat (tx_stat),
        .irq_o   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (dec.rsel)
            RSEL_RX:  bus_rdata = DATA_W'(rx_stat);
            RSEL_TX:  bus_rdata = DATA_W'(tx_stat);
            RSEL_PTR: begin
                for (int i = 0; i < NUM_Q; i++) begin
                    if (dec.q == 8'(i)) bus_rdata = port_ptr[i];
                end
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qcp_intc_chk.sv
module qcp_intc_chk
    import qcp_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int QW    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_Q-1:0]  rx_done,
    input logic              tx_port_we,
    input logic [QW-1:0]     tx_port_q,
    input logic [NUM_Q-1:0]  rx_stat,
    input logic [NUM_Q-1:0]  tx_stat,
    input logic              irq
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (irq == 1'b0 && rx_stat == '0 && tx_stat == '0));

    // R9
    a_r9_irq_delay: assert property (@(posedge clk) disable iff (rst)
        irq == $past((|rx_stat) | (|tx_stat)));

    // R2, R7
    a_r2_rx_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (rx_done != '0) |=> ((rx_stat & $past(rx_done)) == $past(rx_done)));

    // R4, R7
    a_r4_tx_set_sticks: assert property (@(posedge clk) disable iff (rst)
        tx_port_we |=> tx_stat[$past(tx_port_q)]);

    // R5, R6
    a_r5_tx_fall_needs_write: assert property (@(posedge clk) disable iff (rst)
        (($past(tx_stat) & ~tx_stat) != '0) |-> $past(bus_en && bus_wr));

    // R2
    a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && (int'(bus_addr) == OFF_RX_STAT || int'(bus_addr) == OFF_TX_STAT))
        |-> (bus_rdata[DATA_W-1:16] == '0));

    // R10
    a_r10_unaligned_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

bind qcp_intc qcp_intc_chk #(.NUM_Q(NUM_Q), .QW(QW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .rx_done    (rx_done),
    .tx_port_we (tx_port_we),
    .tx_port_q  (tx_port_q),
    .rx_stat    (rx_stat),
    .tx_stat    (tx_stat),
    .irq        (irq)
);

// File: tb/test_qcp_intc.sv
module test_qcp_intc;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] rx_done;
    logic        tx_port_we;
    logic [3:0]  tx_port_q;
    logic [31:0] tx_port_ptr;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    qcp_intc i_qcp_intc (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_done(rx_done),
        .tx_port_we(tx_port_we), .tx_port_q(tx_port_q), .tx_port_ptr(tx_port_ptr), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic port_write(input logic [3:0] q, input logic [31:0] p);
        @(negedge clk);
        tx_port_we = 1; tx_port_q = q; tx_port_ptr = p;
        @(negedge clk);
        tx_port_we = 0;
    endtask

    task automatic rx_pulse(input logic [15:0] m);
        @(negedge clk);
        rx_done = m;
        @(negedge clk);
        rx_done = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(12'h240, v); check("R1 rx status", v, 0);
        bus_read(12'h250, v); check("R1 tx status", v, 0);
        bus_read(12'h28C, v); check("R1 pointer q3", v, 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        rx_pulse(16'h8005);
        check("R9 irq not yet", 32'(irq), 0);
        @(negedge clk);
        check("R9 irq raised", 32'(irq), 1);
        bus_read(12'h240, v); check("R2 rx status set", v, 32'h8005);
        bus_read(12'h248, v); check("R3 rx clear reads zero", v, 0);
        bus_write(12'h248, 32'h0001);
        bus_read(12'h240, v); check("R3 clear bit0", v, 32'h8004);
        bus_write(12'h248, 32'h0000);
        bus_read(12'h240, v); check("R3 zero write no effect", v, 32'h8004);
        bus_write(12'h248, 32'h8004);
        bus_read(12'h240, v); check("R3 all cleared", v, 0);
        check("R9 irq dropped", 32'(irq), 0);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        port_write(4'd5, 32'h1000_0050);
        bus_read(12'h250, v); check("R4 tx bit5 set", v, 32'h20);
        bus_read(12'h294, v); check("R4 pointer stored", v, 32'h1000_0050);
        bus_write(12'h294, 32'h0000_1234);
        bus_read(12'h250, v); check("R5 mismatch keeps bit", v, 32'h20);
        bus_read(12'h294, v); check("R11 read returns port value", v, 32'h1000_0050);
        bus_write(12'h258, 32'h20);
        bus_read(12'h250, v); check("R6 gated clear ignored", v, 32'h20);
        bus_write(12'h294, 32'h1000_0050);
        bus_read(12'h250, v); check("R5 match clears", v, 0);
        port_write(4'd5, 32'h1000_0060);
        bus_read(12'h250, v); check("R8 re-asserted", v, 32'h20);
        bus_write(12'h258, 32'h20);
        bus_read(12'h250, v); check("R6 stale ack blocks clear", v, 32'h20);
        bus_write(12'h294, 32'h1000_0060);
        port_write(4'd2, 32'h0);
        bus_write(12'h258, 32'h4);
        bus_read(12'h250, v); check("R6 equal pointers clear", v, 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        rx_pulse(16'h0002);
        @(negedge clk);
        rx_done = 16'h0002; bus_en = 1; bus_wr = 1; bus_addr = 12'h248; bus_wdata = 32'h2;
        @(negedge clk);
        rx_done = '0; bus_en = 0; bus_wr = 0;
        bus_read(12'h240, v); check("R7 rx set wins", v, 32'h2);
        bus_write(12'h248, 32'h2);
        @(negedge clk);
        tx_port_we = 1; tx_port_q = 4'd7; tx_port_ptr = 32'h77;
        bus_en = 1; bus_wr = 1; bus_addr = 12'h29C; bus_wdata = 32'h0;
        @(negedge clk);
        tx_port_we = 0; bus_en = 0; bus_wr = 0;
        bus_read(12'h250, v); check("R7 tx set wins", v, 32'h80);
        bus_write(12'h29C, 32'h77);
        bus_read(12'h250, v); check("R5 cleanup q7", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rx_pulse(16'h000F);
        bus_write(12'h24C, 32'hFFFF);
        bus_write(12'h2C0, 32'hFFFF);
        bus_write(12'h249, 32'hFFFF);
        bus_read(12'h240, v); check("R10 writes ignored", v, 32'h000F);
        bus_read(12'h24C, v); check("R10 unmapped read", v, 0);
        bus_read(12'h2C0, v); check("R10 past pointers", v, 0);
        bus_read(12'h281, v); check("R10 unaligned", v, 0);
        bus_read(12'h258, v); check("R3 tx clear reads zero", v, 0);
        bus_write(12'h248, 32'hF);
    endtask

    initial begin
        rst = 1; bus_en = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        rx_done = '0; tx_port_we = 0; tx_port_q = '0; tx_port_ptr = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_rx();
        t_tx();
        t_race();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule